// File: doc/BRIEF.md
# Clock-Independent Level Event Latch Bank

This block watches eight input lines for an active level and records each hit in a sticky flag per channel. The polarity is set per channel. The flag is set asynchronously by the input condition itself, so a short event is still caught while the bus clock is gated off. Once the clock runs, the flag is brought into the clock domain through a synchronizer chain. It then shows up in the raw status, is gated by the per-channel enable into the masked status, and drives one shared interrupt line.

Software sets the polarity, enable and capture mode of each channel through a small word-addressed register file. It acknowledges events by writing ones to the clear register. Only level detection exists in hardware. To get edge behaviour, software flips the polarity after each event it services. The clear cannot win against a condition that is still present, so a level that persists comes straight back.

Top module: `lvl_latch_bank`

## Requirements
- R1: After reset the enable and polarity registers read 0x00, the mode register reads 0xFF, raw and masked status read 0x00, and irq_o is low.
- R2: With polarity bit 0 a channel detects a high input level. The hit is visible in raw status (offset 0x04) after the second rising clock edge following the input change, and not after the first.
- R3: With polarity bit 1 (offset 0x10) a channel detects a low input level.
- R4: With the mode bit at 1 (offset 0x14, latched), a detected event stays in raw status after the input returns to its inactive level, until it is cleared.
- R5: With the mode bit at 0 (transparent), raw status follows the present level condition through the synchronizer and holds nothing.
- R6: Writing a 1 to a bit of the clear register (offset 0x0C) removes that channel's latched event. Bits written as 0 leave their channels unchanged. The clear register reads back 0x00.
- R7: A clear that lands while the channel's level condition is still active leaves the raw status bit set.
- R8: Masked status (offset 0x08) equals raw status AND enable (offset 0x00). irq_o is high exactly when masked status is non-zero.
- R9: An event that starts and ends while the clock is stopped is captured, and appears in raw status once the clock resumes.
- R10: Writes to the raw and masked status offsets change nothing. Reads from unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, may be stopped |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_CH | Level event inputs, one per channel |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | NUM_CH | Write data |
| rdata_o | output | NUM_CH | Read data for addr_i, combinational |
| irq_o | output | 1 | Combined interrupt, OR of masked status |

## Verification
The hold and clear-versus-hit properties sample the level condition at the clock edge. They assume pin_i and polarity do not change in the same instant as a rising clock edge. The bench keeps to this by driving every input and register write on the falling edge. In the stopped-clock test it moves the pins only while the clock is held low. The bench also clears all channels after each mode change, because a stale capture left from transparent mode is accepted behaviour and is not checked.

// File: rtl/lvl_latch_pkg.sv
package lvl_latch_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFF_EN   = 5'h00,
    OFF_RAW  = 5'h04,
    OFF_MSK  = 5'h08,
    OFF_CLR  = 5'h0C,
    OFF_POL  = 5'h10,
    OFF_MODE = 5'h14
  } reg_off_e;
endpackage

// File: rtl/lvl_latch_cell.sv
module lvl_latch_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  input  logic latch_i,
  input  logic clr_i,
  output logic stat_o
);
  logic hit;
  logic cap_q;
  logic src;
  logic [SYNC_STAGES-1:0] sync_q;

  // pol 0 = active high, pol 1 = active low
  assign hit = pin_i ^ pol_i;

  // set needs no clock; clear only on a clock edge and loses to a live hit
  always_ff @(posedge clk_i or negedge rst_ni or posedge hit) begin
    if (!rst_ni)    cap_q <= 1'b0;
    else if (hit)   cap_q <= 1'b1;
    else if (clr_i) cap_q <= 1'b0;
  end

  assign src = latch_i ? cap_q : hit;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= src;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], src};
      end
    end
  endgenerate

  assign stat_o = sync_q[SYNC_STAGES-1];

  a_r4_capture_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q && !clr_i) |=> cap_q);

  a_r7_clear_loses_to_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit) |=> cap_q);

  a_r6_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit && !$rose(hit)) |=> (!cap_q || hit));
endmodule

// File: rtl/lvl_latch_regs.sv
module lvl_latch_regs
  import lvl_latch_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [NUM_CH-1:0] raw_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] pol_o,
  output logic [NUM_CH-1:0] latch_o,
  output logic [NUM_CH-1:0] clr_o,
  output logic [NUM_CH-1:0] msk_o,
  output logic [NUM_CH-1:0] rdata_o
);
  logic [NUM_CH-1:0] en_q, pol_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '1;
    end else if (we_i) begin
      if (addr_i == OFF_EN)   en_q   <= wdata_i;
      if (addr_i == OFF_POL)  pol_q  <= wdata_i;
      if (addr_i == OFF_MODE) mode_q <= wdata_i;
    end
  end

  assign clr_o   = (we_i && addr_i == OFF_CLR) ? wdata_i : '0;
  assign msk_o   = raw_i & en_q;
  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign latch_o = mode_q;

  always_comb begin
    case (addr_i)
      OFF_EN:   rdata_o = en_q;
      OFF_RAW:  rdata_o = raw_i;
      OFF_MSK:  rdata_o = msk_o;
      OFF_POL:  rdata_o = pol_q;
      OFF_MODE: rdata_o = mode_q;
      default:  rdata_o = '0;
    endcase
  end

  a_r10_en_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == OFF_EN) |=> $stable(en_q));

  a_r10_pol_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == OFF_POL) |=> $stable(pol_q));
endmodule

// File: rtl/lvl_latch_bank.sv
module lvl_latch_bank
  import lvl_latch_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              we_i,
  input  logic [4:0]        addr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] raw, en, pol, latch, clr, msk;

  lvl_latch_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .raw_i   (raw),
    .en_o    (en),
    .pol_o   (pol),
    .latch_o (latch),
    .clr_o   (clr),
    .msk_o   (msk),
    .rdata_o (rdata_o)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      lvl_latch_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i[c]),
        .pol_i   (pol[c]),
        .latch_i (latch[c]),
        .clr_i   (clr[c]),
        .stat_o  (raw[c])
      );
    end
  endgenerate

  assign irq_o = |msk;

  a_r8_no_irq_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);

  a_r8_no_irq_without_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw == '0) |-> !irq_o);
endmodule

// File: tb/lvl_latch_bank_test.sv
module lvl_latch_bank_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pin_i = '0;
  logic       we_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;
  logic       clk_run = 1'b1;
  int n_chk = 0;
  int n_fail = 0;

  localparam logic [4:0] A_EN = 5'h00, A_RAW = 5'h04, A_MSK = 5'h08,
                         A_CLR = 5'h0C, A_POL = 5'h10, A_MODE = 5'h14;

  // {pol, pin, en, exp_raw, exp_msk}
  localparam logic [39:0] VEC [0:5] = '{
    {8'h00, 8'h0F, 8'hFF, 8'h0F, 8'h0F},
    {8'hFF, 8'h0F, 8'hFF, 8'hF0, 8'hF0},
    {8'h00, 8'hA5, 8'h0F, 8'hA5, 8'h05},
    {8'h3C, 8'h3C, 8'hFF, 8'h00, 8'h00},
    {8'h0F, 8'h00, 8'hF0, 8'h0F, 8'h00},
    {8'h81, 8'h80, 8'h01, 8'h01, 8'h01}
  };

  lvl_latch_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always begin
    #10;
    if (clk_run) clk_i = ~clk_i;
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr_i = a;
    #2;
    d = rdata_o;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset values
    rd(A_EN, v);   check("R1 en", v, 8'h00);
    rd(A_POL, v);  check("R1 pol", v, 8'h00);
    rd(A_MODE, v); check("R1 mode", v, 8'hFF);
    rd(A_RAW, v);  check("R1 raw", v, 8'h00);
    rd(A_MSK, v);  check("R1 msk", v, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);

    // R2 R3 R8 vector table
    for (int i = 0; i < 6; i++) begin
      wr(A_POL, VEC[i][39:32]);
      wr(A_EN, VEC[i][23:16]);
      @(negedge clk_i);
      pin_i = VEC[i][31:24];
      wr(A_CLR, 8'hFF);
      settle();
      rd(A_RAW, v); check("R2/R3 raw", v, VEC[i][15:8]);
      rd(A_MSK, v); check("R8 msk", v, VEC[i][7:0]);
      check("R8 irq", {7'd0, irq_o}, {7'd0, |VEC[i][7:0]});
    end

    // return to idle
    pin_i = 8'h00;
    wr(A_POL, 8'h00);
    wr(A_EN, 8'h00);
    wr(A_CLR, 8'hFF);
    settle();
    rd(A_RAW, v); check("R6 idle", v, 8'h00);

    // R2 latency: not after first edge, present after second
    pin_i = 8'h10;
    @(negedge clk_i);
    rd(A_RAW, v); check("R2 one edge", v, 8'h00);
    @(negedge clk_i);
    rd(A_RAW, v); check("R2 two edges", v, 8'h10);
    pin_i = 8'h00;
    wr(A_CLR, 8'hFF);
    settle();

    // R4 sticky capture
    pin_i = 8'h24;
    @(negedge clk_i);
    pin_i = 8'h00;
    settle();
    rd(A_RAW, v); check("R4 sticky", v, 8'h24);
    rd(A_MSK, v); check("R8 masked off", v, 8'h00);
    check("R8 irq off", {7'd0, irq_o}, 8'h00);
    wr(A_EN, 8'h04);
    rd(A_MSK, v); check("R8 masked one", v, 8'h04);
    check("R8 irq on", {7'd0, irq_o}, 8'h01);

    // R6 selective clear
    wr(A_CLR, 8'h04);
    settle();
    rd(A_RAW, v); check("R6 bit cleared", v, 8'h20);
    check("R8 irq dropped", {7'd0, irq_o}, 8'h00);
    rd(A_CLR, v); check("R6 clr reads 0", v, 8'h00);

    // R7 clear while active
    pin_i = 8'h02;
    settle();
    wr(A_CLR, 8'h02);
    settle();
    rd(A_RAW, v); check("R7 held", v, 8'h22);
    pin_i = 8'h00;
    wr(A_CLR, 8'hFF);
    settle();
    rd(A_RAW, v); check("R7 released", v, 8'h00);

    // R10 read-only and unmapped
    pin_i = 8'h01;
    @(negedge clk_i);
    pin_i = 8'h00;
    settle();
    wr(A_RAW, 8'h00);
    wr(A_MSK, 8'hFF);
    settle();
    rd(A_RAW, v);  check("R10 raw write ignored", v, 8'h01);
    rd(A_EN, v);   check("R10 en unchanged", v, 8'h04);
    rd(5'h18, v);  check("R10 unmapped", v, 8'h00);
    wr(A_POL, 8'h5A);
    rd(A_POL, v);  check("R10 pol readback", v, 8'h5A);
    wr(A_POL, 8'h00);
    wr(A_CLR, 8'hFF);
    settle();

    // R5 transparent mode
    wr(A_MODE, 8'h00);
    pin_i = 8'h08;
    settle();
    rd(A_RAW, v); check("R5 live high", v, 8'h08);
    pin_i = 8'h00;
    settle();
    rd(A_RAW, v); check("R5 live low", v, 8'h00);
    wr(A_MODE, 8'hFF);
    wr(A_CLR, 8'hFF);
    settle();

    // R9 capture with clock stopped
    clk_run = 1'b0;
    #50 pin_i = 8'h40;
    #50 pin_i = 8'h00;
    #50 clk_run = 1'b1;
    repeat (4) @(negedge clk_i);
    rd(A_RAW, v); check("R9 stopped clock", v, 8'h40);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule